// File: doc/BRIEF.md
# Hexadecimal Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit radix-16 floating-point words in one cycle and registers the result. A word packs a sign bit at bit 31, a 7-bit characteristic in bits 30:24 that holds the exponent plus 64, and a fraction of six hex digits in bits 23:0. The value of a non-negative word is fraction × 16^(characteristic − 64), with the fraction read as a number between 0 and 1. A negative value is held as the two's complement of the entire 32-bit word of its magnitude.

Both operands are first converted to sign and magnitude. In subtract mode the sign of the second operand is inverted. The operand with the smaller characteristic is shifted right by whole hex digits. The magnitudes are then added, or the smaller is subtracted from the larger. The sum is normalized to a nonzero leading digit, optionally rounded on an extra guard digit, and converted back to the signed word form. A start strobe launches an operation. The result, together with the overflow and underflow flags, appears one clock later with a done strobe.

Top module: `hfp_addsub`

## Requirements
- R1: For two operands of the same effective sign, result_o is their sum in the word format: sign bit 31, characteristic bits 30:24 with bias 64, fraction bits 23:0 holding six hex digits.
- R2: Operands with bit 31 set are read as the two's complement of the whole word of their magnitude. A negative result is emitted as the two's complement of the whole word of its magnitude (−1.0 is 0xBEF00000).
- R3: With sub_i = 1 the second operand is subtracted. For mixed effective signs the result takes the sign of the operand with the larger aligned magnitude.
- R4: A zero sum is emitted as the all-zero word with both flags clear.
- R5: The operand with the smaller characteristic is shifted right one hex digit per unit of characteristic difference. At a difference of 7 or more it contributes nothing.
- R6: A carry out of the top fraction digit shifts the sum right one hex digit and adds one to the characteristic.
- R7: A nonzero result is postnormalized by left shifts of one hex digit, each lowering the characteristic by one, until fraction bits 23:20 are nonzero.
- R8: With round_en_i = 1 the aligned operands and the sum keep one guard hex digit below the fraction. After normalization a guard value of 8 to 15 adds one to the fraction, and a carry from that increment renormalizes as in R6.
- R9: With round_en_i = 0 the digits shifted out of the smaller operand are dropped before the add, and the result is truncated.
- R10: A final characteristic above 127 raises ovf_o and forces result_o to zero.
- R11: A final characteristic below 0 raises unf_o and forces result_o to zero.
- R12: A negative result never has a zero fraction field. A negative magnitude of exactly 1/16 × 16^e is emitted with fraction field 0xF00000.
- R13: done_o is high in exactly the cycle after the start_i cycle. result_o, ovf_o and unf_o change only on a start and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation on the present operands |
| sub_i | input | 1 | 1: a_i − b_i, 0: a_i + b_i |
| round_en_i | input | 1 | 1: round on the guard digit, 0: truncate |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| done_o | output | 1 | Result valid strobe |
| result_o | output | 32 | Result word |
| ovf_o | output | 1 | Characteristic overflow |
| unf_o | output | 1 | Characteristic underflow |

## Verification
Every result is due exactly one clock after the edge that samples start_i, and operations may be launched on consecutive cycles. The driver queues the expected word and flags when it raises start_i. The monitor samples on the falling edge and takes one expected item each time done_o is high, so any extra, missing or late result shows up as a mismatch or a leftover queue entry. After the final result the bench idles several cycles and checks that done_o stays low and that the outputs hold.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int EXP_W   = 7;
  localparam int DIG_W   = 4;
  localparam int FDIGITS = 6;
  localparam int FRAC_W  = FDIGITS * DIG_W;
  localparam int GUARD_W = DIG_W;
  localparam int EXT_W   = FRAC_W + GUARD_W;
  localparam int DIGITS  = EXT_W / DIG_W;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int ESW     = EXP_W + 2;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  chr;
    logic [FRAC_W-1:0] frac;
  } hfp_op_t;
endpackage

// File: rtl/hfp_unpack.sv
module hfp_unpack
  import hfp_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] word_i,
  input  logic         flip_i,
  output hfp_op_t      op_o
);
  logic [W-1:0] mag;

  always_comb begin
    mag = word_i[W-1] ? (~word_i + 1'b1) : word_i;
    op_o.sign = word_i[W-1] ^ flip_i;
    op_o.chr  = mag[W-2 -: EXP_W];
    op_o.frac = mag[FRAC_W-1:0];
  end
endmodule

// File: rtl/hfp_align_add.sv
module hfp_align_add
  import hfp_pkg::*;
#(
  parameter int XW = EXT_W
) (
  input  hfp_op_t          a_i,
  input  hfp_op_t          b_i,
  input  logic             round_en_i,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [XW:0]      sum_o
);
  localparam int ND = XW / DIG_W;

  logic             a_big;
  hfp_op_t          big, sml;
  logic [EXP_W-1:0] diff;
  logic [XW-1:0]    big_x, sml_x, sml_al;

  always_comb begin
    a_big = a_i.chr >= b_i.chr;
    big   = a_big ? a_i : b_i;
    sml   = a_big ? b_i : a_i;
    diff  = big.chr - sml.chr;
    big_x = {big.frac, {GUARD_W{1'b0}}};
    sml_x = {sml.frac, {GUARD_W{1'b0}}};
    if (diff >= EXP_W'(ND)) sml_al = '0;
    else                    sml_al = sml_x >> (int'(diff) * DIG_W);
    if (!round_en_i) sml_al[GUARD_W-1:0] = '0;  // no guard digit when truncating
    exp_o = big.chr;
    if (big.sign != sml.sign) begin
      if (big_x >= sml_al) begin
        sum_o  = {1'b0, big_x - sml_al};
        sign_o = big.sign;
      end else begin
        sum_o  = {1'b0, sml_al - big_x};
        sign_o = sml.sign;
      end
    end else begin
      sum_o  = {1'b0, big_x} + {1'b0, sml_al};
      sign_o = big.sign;
    end
  end
endmodule

// File: rtl/hfp_norm_round.sv
module hfp_norm_round
  import hfp_pkg::*;
#(
  parameter int XW = EXT_W
) (
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [XW:0]       sum_i,
  input  logic              round_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int ND = XW / DIG_W;
  localparam logic signed [ESW-1:0] E_MAX = ESW'((1 << EXP_W) - 1);

  logic                  zero;
  logic [XW-1:0]         m;
  logic signed [ESW-1:0] e;
  int                    lz;
  logic [FRAC_W:0]       f;
  logic [WORD_W-1:0]     mag_w;

  always_comb begin
    zero = (sum_i == '0);
    e    = $signed({{(ESW-EXP_W){1'b0}}, exp_i});
    lz   = 0;
    if (sum_i[XW]) begin
      m = XW'(sum_i >> DIG_W);
      e = e + ESW'(1);
    end else begin
      lz = ND;
      for (int i = 0; i < ND; i++)
        if (sum_i[i*DIG_W +: DIG_W] != '0) lz = ND - 1 - i;
      if (zero) lz = 0;
      m = sum_i[XW-1:0] << (lz * DIG_W);
      e = e - ESW'(lz);
    end
    f = {1'b0, m[XW-1:GUARD_W]};
    if (round_en_i && m[GUARD_W-1]) f = f + 1'b1;
    if (f[FRAC_W]) begin  // rounding carried past the top digit
      f = f >> DIG_W;
      e = e + ESW'(1);
    end
    ovf_o = !zero && (e > E_MAX);
    unf_o = !zero && e[ESW-1];
    mag_w = {1'b0, e[EXP_W-1:0], f[FRAC_W-1:0]};
    if (zero || ovf_o || unf_o) word_o = '0;
    else                        word_o = sign_i ? (~mag_w + 1'b1) : mag_w;
  end
endmodule

// File: rtl/hfp_addsub.sv
module hfp_addsub
  import hfp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              round_en_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              ovf_o,
  output logic              unf_o
);
  hfp_op_t           op_a, op_b;
  logic              sum_sign;
  logic [EXP_W-1:0]  sum_exp;
  logic [EXT_W:0]    sum;
  logic [WORD_W-1:0] word_d;
  logic              ovf_d, unf_d;

  hfp_unpack #(.W(WORD_W)) u_unp_a (.word_i(a_i), .flip_i(1'b0),  .op_o(op_a));
  hfp_unpack #(.W(WORD_W)) u_unp_b (.word_i(b_i), .flip_i(sub_i), .op_o(op_b));

  hfp_align_add #(.XW(EXT_W)) u_add (
    .a_i(op_a), .b_i(op_b), .round_en_i(round_en_i),
    .sign_o(sum_sign), .exp_o(sum_exp), .sum_o(sum)
  );

  hfp_norm_round #(.XW(EXT_W)) u_norm (
    .sign_i(sum_sign), .exp_i(sum_exp), .sum_i(sum), .round_en_i(round_en_i),
    .word_o(word_d), .ovf_o(ovf_d), .unf_o(unf_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        result_o <= word_d;
        ovf_o    <= ovf_d;
        unf_o    <= unf_d;
      end
    end
  end
endmodule

// File: rtl/hfp_addsub_chk.sv
module hfp_addsub_chk
  import hfp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              sub_i,
  input logic              round_en_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              done_o,
  input logic [WORD_W-1:0] result_o,
  input logic              ovf_o,
  input logic              unf_o
);
  p_done_after_start_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  p_no_spurious_done_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  p_hold_result_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(ovf_o) && $stable(unf_o)));
  p_ovf_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (result_o == '0 && !unf_o));
  p_unf_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (result_o == '0 && !ovf_o));
  p_neg_frac_nonzero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o[WORD_W-1] |-> (result_o[FRAC_W-1:0] != '0));
  p_normalized_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (result_o != '0 && !result_o[WORD_W-1]) |-> (result_o[FRAC_W-1 -: DIG_W] != '0));
endmodule

bind hfp_addsub hfp_addsub_chk u_chk (.*);

// File: tb/hfp_addsub_tb.sv
`timescale 1ns/1ps
module hfp_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sub = 1'b0, rnd = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        done, ovf, unf;
  logic [31:0] res;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] w;
    logic        ovf;
    logic        unf;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;

  hfp_addsub u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sub_i(sub), .round_en_i(rnd),
    .a_i(a), .b_i(b), .done_o(done), .result_o(res), .ovf_o(ovf), .unf_o(unf)
  );

  function automatic exp_t model(logic [31:0] x, logic [31:0] y, logic s, logic r);
    exp_t   o;
    logic [31:0] mx, my, wd;
    logic   sx, sy, neg;
    longint vx, vy, sum, mag, fr, g;
    int     ex, ey, e;
    sx = x[31];  mx = sx ? (~x + 32'd1) : x;
    sy = y[31] ^ s; my = y[31] ? (~y + 32'd1) : y;
    ex = int'(mx[30:24]); ey = int'(my[30:24]);
    vx = longint'(mx[23:0]) * 16;
    vy = longint'(my[23:0]) * 16;
    while (ex < ey) begin vx = vx / 16; ex++; end
    while (ey < ex) begin vy = vy / 16; ey++; end
    if (!r) begin vx = vx - (vx % 16); vy = vy - (vy % 16); end
    e = ex;
    if (sx) vx = -vx;
    if (sy) vy = -vy;
    sum = vx + vy;
    neg = (sum < 0);
    mag = neg ? -sum : sum;
    o.w = '0; o.ovf = 1'b0; o.unf = 1'b0; o.tag = "";
    if (mag == 0) return o;
    while (mag >= (64'd1 << 28)) begin mag = mag / 16; e++; end
    while (mag <  (64'd1 << 24)) begin mag = mag * 16; e--; end
    fr = mag / 16; g = mag % 16;
    if (r && g >= 8) fr++;
    if (fr >= (64'd1 << 24)) begin fr = fr / 16; e++; end
    if (e > 127) begin o.ovf = 1'b1; return o; end
    if (e < 0)   begin o.unf = 1'b1; return o; end
    wd = {1'b0, 7'(e), 24'(fr)};
    o.w = neg ? (~wd + 32'd1) : wd;
    return o;
  endfunction

  task automatic drive(input logic [31:0] x, input logic [31:0] y,
                       input logic s, input logic r, input string tag);
    exp_t e;
    e = model(x, y, s, r);
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    a = x; b = y; sub = s; rnd = r; start = 1'b1;
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected done: got %h exp none", res);
      end else begin
        e = sb.pop_front();
        if (res !== e.w || ovf !== e.ovf || unf !== e.unf) begin
          errors++;
          $display("FAIL %s got %h ovf%0b unf%0b exp %h ovf%0b unf%0b",
                   e.tag, res, ovf, unf, e.w, e.ovf, e.unf);
        end
      end
    end
  end

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk_val(input logic [31:0] got, input logic [31:0] expv, input string tag);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, expv);
    end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk_val({29'd0, done, ovf, unf}, 32'd0, "R13 reset flags");
    chk_val(res, 32'd0, "R13 reset result");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed
    drive(32'h41100000, 32'h41100000, 0, 0, "R1 1+1");
    drive(32'h41100000, 32'h41100000, 1, 1, "R4 1-1");
    drive(32'h41100000, 32'hBEF00000, 0, 0, "R2 1+(-1)");
    drive(32'h41800000, 32'h41800000, 0, 1, "R6 8+8 carry");
    drive(32'h41100000, 32'h3B800000, 0, 1, "R8 guard 8 rounds up");
    drive(32'h41100000, 32'h3B800000, 0, 0, "R9 truncate guard");
    drive(32'h41FFFFFF, 32'h3B800000, 0, 1, "R8 round carry");
    drive(32'h41100000, 32'h41200000, 1, 0, "R3 1-2 negative");
    drive(32'hBEF00000, 32'h41100000, 1, 0, "R12 -1-1");
    drive(32'h41100000, 32'hBE800000, 0, 0, "R12 neg 1/16 form");
    drive(32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, "R10 overflow");
    drive(32'h00110000, 32'h00100000, 1, 0, "R11 underflow");
    drive(32'h41100000, 32'h3B100000, 1, 1, "R7 normalize via guard");
    drive(32'h41100000, 32'h3B100000, 1, 0, "R9 no guard on sub");
    drive(32'h41100000, 32'h3A800000, 0, 1, "R5 diff 7 ignored");
    drive(32'h42123456, 32'h41100000, 0, 0, "R5 one digit align");
    drive(32'h41100000, 32'h40FFFFFF, 1, 1, "R7 multi-digit normalize");
    drive(32'h00000000, 32'h00000000, 0, 1, "R4 zero+zero");
    idle();

    // random, narrow characteristic spread
    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = (i % 2 == 0) ? (x ^ ($urandom & 32'h03FFFFFF)) : $urandom;
      drive(x, y, 1'($urandom), 1'($urandom), "R1 random");
      if (i % 17 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);

    // outputs hold with no start
    held = res;
    repeat (4) @(negedge clk);
    chk_val(res, held, "R13 hold result");
    chk_val({31'd0, done}, 32'd0, "R13 done low idle");
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R13 missing results: got %0d pending exp 0", sb.size());
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule